// File: doc/BRIEF.md
# Control-Word Driven Register Datapath

This block is the data-processing half of a small processor. Each clock cycle it takes one 16-bit instruction and decodes it into a set of steering fields: the register that drives operand bus A, the register that drives operand bus B, the function to perform, whether the shifter or the arithmetic-logic unit supplies the function result, whether the write-back value comes from that result or from the external data input, the destination register, and a load enable. Two registers of the eight-entry file are read combinationally. The function unit combines them, and the selected write-back value is stored into the destination register on the next rising clock edge.

Four status flags accompany every executed operation: carry, negative, zero and signed overflow. They are registered and change only in cycles that write a register. The data input stands in for a memory read bus. An unrecognised opcode performs no write and leaves the flags unchanged, so it also serves as a way to look at a register through operand bus A without disturbing any state.

Top module: `cwdp_top`

## Requirements
- R1: The instruction word is split as opcode = bits 15..9, destination = bits 8..6, first source = bits 5..3 and second source = bits 2..0. The output `a_bus` always shows the current content of the register named by the first source field.
- R2: While `rst_n` is 0 at a rising clock edge, all eight registers and all four flags are cleared to 0.
- R3: Opcode 0000000 writes the first source unchanged to the destination. Opcode 0000001 writes the first source plus 1. Opcode 0000010 writes first source plus second source. For all three, carry is the unsigned carry out of bit 15.
- R4: Opcode 0000101 writes first source minus second source. Carry is the carry out of A + ~B + 1, which is 1 exactly when A >= B as unsigned numbers.
- R5: Overflow is 1 when the result of an add, increment or subtract does not fit in a signed 16-bit two's-complement number. Overflow is 0 for every other opcode.
- R6: Opcodes 0001000 (AND), 0001001 (OR) and 0001010 (XOR) combine A and B bitwise. Opcode 0001011 writes the bitwise inverse of A. For all four, carry and overflow are 0.
- R7: Opcode 0001101 writes the second source shifted right by one bit. Opcode 0001110 writes the second source shifted left by one bit. Both shifts fill the vacated bit with 0, and both clear carry and overflow.
- R8: Opcode 0010000 writes `data_in` to the destination and clears carry and overflow.
- R9: On a writing cycle, the negative flag becomes bit 15 of the written value, and the zero flag becomes 1 exactly when the written value is 0.
- R10: Any other opcode drives `load_en` to 0. Such an opcode writes no register and leaves all four flags unchanged.
- R11: A write takes effect at the rising edge that ends the cycle. Flags change only on a cycle in which `load_en` is 1. A read of the destination register in the writing cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 16 | Instruction: opcode, destination, first source, second source |
| data_in | input | 16 | External data bus value for the load-data opcode |
| a_bus | output | 16 | Content of the register named by the first source field |
| wb_bus | output | 16 | Value that will be written this cycle |
| load_en | output | 1 | 1 when this instruction writes a register |
| flag_c | output | 1 | Registered carry flag |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_v | output | 1 | Registered signed-overflow flag |

## Verification
The arithmetic opcodes are driven with ordinary operands, with operands that produce unsigned carry only (FFFF+1), with operands that produce signed overflow only (7FFF+1, 8000-1), and with equal operands and a borrow on subtract. Together these separate the carry path from the overflow path and exercise the zero flag. The logic and shift opcodes use alternating bit patterns, so that a swapped operand, a wrong fill bit or a wrong shift direction gives a visibly different word. Unrecognised opcodes are placed straight after flag-setting operations, which exposes any write or flag change that should not happen. A long pseudo-random run mixes all opcodes and register indices, including writes to a register that the same instruction reads.

// File: rtl/cwdp_pkg.sv
// Package: shared widths, opcodes and the decoded control word.
// Assumes a fixed 16-bit instruction layout: opcode / dest / src A / src B.
package cwdp_pkg;
    parameter int DATA_W = 16;
    parameter int NREG   = 8;
    parameter int OP_W   = 7;
    localparam int SEL_W = $clog2(NREG);

    localparam logic [OP_W-1:0] OPC_MOVA = 7'b0000000;
    localparam logic [OP_W-1:0] OPC_INC  = 7'b0000001;
    localparam logic [OP_W-1:0] OPC_ADD  = 7'b0000010;
    localparam logic [OP_W-1:0] OPC_SUB  = 7'b0000101;
    localparam logic [OP_W-1:0] OPC_AND  = 7'b0001000;
    localparam logic [OP_W-1:0] OPC_OR   = 7'b0001001;
    localparam logic [OP_W-1:0] OPC_XOR  = 7'b0001010;
    localparam logic [OP_W-1:0] OPC_NOT  = 7'b0001011;
    localparam logic [OP_W-1:0] OPC_SHR  = 7'b0001101;
    localparam logic [OP_W-1:0] OPC_SHL  = 7'b0001110;
    localparam logic [OP_W-1:0] OPC_LDB  = 7'b0010000;

    typedef enum logic [2:0] {
        FS_PASS, FS_INC, FS_ADD, FS_SUB, FS_AND, FS_OR, FS_XOR, FS_INV
    } fsel_t;

    typedef struct packed {
        logic [SEL_W-1:0] asel;
        logic [SEL_W-1:0] bsel;
        logic [SEL_W-1:0] dsel;
        fsel_t            fs;
        logic             use_shift;   // function result comes from shifter
        logic             shift_left;  // shifter direction
        logic             wb_from_bus; // write-back takes data_in
        logic             load;
    } ctl_t;
endpackage

// File: rtl/cwdp_decode.sv
// Decoder: turns an instruction into the control word.
// Assumes the package opcode set; any other opcode yields load = 0.
module cwdp_decode
    import cwdp_pkg::*;
(
    input  logic [DATA_W-1:0] instr,
    output ctl_t              ctl
);
    logic [OP_W-1:0] opc;
    assign opc = instr[DATA_W-1 -: OP_W];

    // Map the opcode to function, source and load fields.
    always_comb begin
        ctl             = '0;
        ctl.dsel        = instr[3*SEL_W-1 -: SEL_W];
        ctl.asel        = instr[2*SEL_W-1 -: SEL_W];
        ctl.bsel        = instr[SEL_W-1:0];
        ctl.fs          = FS_PASS;
        ctl.load        = 1'b1;
        case (opc)
            OPC_MOVA: ctl.fs = FS_PASS;
            OPC_INC:  ctl.fs = FS_INC;
            OPC_ADD:  ctl.fs = FS_ADD;
            OPC_SUB:  ctl.fs = FS_SUB;
            OPC_AND:  ctl.fs = FS_AND;
            OPC_OR:   ctl.fs = FS_OR;
            OPC_XOR:  ctl.fs = FS_XOR;
            OPC_NOT:  ctl.fs = FS_INV;
            OPC_SHR:  ctl.use_shift = 1'b1;
            OPC_SHL: begin
                ctl.use_shift  = 1'b1;
                ctl.shift_left = 1'b1;
            end
            OPC_LDB:  ctl.wb_from_bus = 1'b1;
            default:  ctl.load = 1'b0;
        endcase
    end
endmodule

// File: rtl/cwdp_regfile.sv
// Register file: NREG words, two combinational reads, one clocked write.
// Assumes synchronous active-low reset clearing every word.
module cwdp_regfile #(
    parameter int DW = 16,
    parameter int N  = 8,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] mem [N];

    // Clear on reset, otherwise store the write-back word when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Combinational read ports.
    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(waddr)] == $past(wdata))); // R11
endmodule

// File: rtl/cwdp_fu.sv
// Function unit: ALU (shared adder for inc/add/sub) plus a one-bit shifter.
// Carry and overflow are only meaningful for the adder operations.
module cwdp_fu
    import cwdp_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  fsel_t         fs,
    input  logic          use_shift,
    input  logic          shift_left,
    output logic [DW-1:0] f,
    output logic          carry,
    output logic          ovf
);
    logic [DW-1:0] y;
    logic          cin;
    logic [DW:0]   sum;
    logic [DW-1:0] alu_f;
    logic [DW-1:0] sh_f;
    logic          arith;

    // Choose the second adder operand and carry-in.
    always_comb begin
        y   = '0;
        cin = 1'b0;
        case (fs)
            FS_INC:  cin = 1'b1;
            FS_ADD:  y   = b;
            FS_SUB: begin
                y   = ~b;
                cin = 1'b1;
            end
            default: ;
        endcase
    end

    assign sum   = {1'b0, a} + {1'b0, y} + {{DW{1'b0}}, cin};
    assign arith = !use_shift && (fs == FS_INC || fs == FS_ADD || fs == FS_SUB);

    // Select the ALU output word.
    always_comb begin
        case (fs)
            FS_AND:  alu_f = a & b;
            FS_OR:   alu_f = a | b;
            FS_XOR:  alu_f = a ^ b;
            FS_INV:  alu_f = ~a;
            FS_INC, FS_ADD, FS_SUB: alu_f = sum[DW-1:0];
            default: alu_f = a;
        endcase
    end

    assign sh_f  = shift_left ? {b[DW-2:0], 1'b0} : {1'b0, b[DW-1:1]};
    assign f     = use_shift ? sh_f : alu_f;
    assign carry = arith & sum[DW];
    assign ovf   = arith & (a[DW-1] == y[DW-1]) & (sum[DW-1] != a[DW-1]);
endmodule

// File: rtl/cwdp_top.sv
// Top: decoder, register file, function unit, write-back mux and flag register.
// Assumes one instruction per cycle; flags update only on writing cycles.
module cwdp_top
    import cwdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] instr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] a_bus,
    output logic [DATA_W-1:0] wb_bus,
    output logic              load_en,
    output logic              flag_c,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v
);
    ctl_t              ctl;
    logic [DATA_W-1:0] b_bus;
    logic [DATA_W-1:0] fu_f;
    logic              fu_c;
    logic              fu_v;

    cwdp_decode u_dec (.instr(instr), .ctl(ctl));

    cwdp_regfile #(.DW(DATA_W), .N(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(ctl.load), .waddr(ctl.dsel),
        .wdata(wb_bus), .raddr_a(ctl.asel), .raddr_b(ctl.bsel),
        .rdata_a(a_bus), .rdata_b(b_bus)
    );

    cwdp_fu #(.DW(DATA_W)) u_fu (
        .a(a_bus), .b(b_bus), .fs(ctl.fs), .use_shift(ctl.use_shift),
        .shift_left(ctl.shift_left), .f(fu_f), .carry(fu_c), .ovf(fu_v)
    );

    assign wb_bus  = ctl.wb_from_bus ? data_in : fu_f;
    assign load_en = ctl.load;

    // Capture status of the written value on writing cycles only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {flag_c, flag_n, flag_z, flag_v} <= '0;
        end else if (ctl.load) begin
            flag_c <= !ctl.wb_from_bus && fu_c;
            flag_v <= !ctl.wb_from_bus && fu_v;
            flag_n <= wb_bus[DATA_W-1];
            flag_z <= (wb_bus == '0);
        end
    end

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable({flag_c, flag_n, flag_z, flag_v})); // R10
    AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !ctl.use_shift && !ctl.wb_from_bus &&
         (ctl.fs == FS_AND || ctl.fs == FS_OR || ctl.fs == FS_XOR || ctl.fs == FS_INV))
        |=> (!flag_c && !flag_v)); // R6
    AST_SUB_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && ctl.fs == FS_SUB && !ctl.use_shift && !ctl.wb_from_bus)
        |-> (wb_bus == DATA_W'(a_bus - b_bus))); // R4
    AST_SHIFT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && ctl.use_shift) |=> (!flag_v && !flag_c)); // R7
endmodule

// File: tb/cwdp_top_bench.sv
`timescale 1ns/1ps
module cwdp_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = 16'hFE00;
    logic [15:0] data_in = 16'h0000;
    logic [15:0] a_bus, wb_bus;
    logic        load_en, flag_c, flag_n, flag_z, flag_v;

    int checks = 0;
    int fails  = 0;

    logic [15:0] mr [8];
    logic        mc, mn, mz, mv;

    always #2.5 clk = ~clk;

    cwdp_top u_cwdp_top (
        .clk(clk), .rst_n(rst_n), .instr(instr), .data_in(data_in),
        .a_bus(a_bus), .wb_bus(wb_bus), .load_en(load_en),
        .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v)
    );

    function automatic logic [15:0] mk(logic [6:0] op, int d, int a, int b);
        return {op, 3'(d), 3'(a), 3'(b)};
    endfunction

    task automatic chk(logic [15:0] act, logic [15:0] exp, string req, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Behavioural reference of one instruction.
    task automatic model(input logic [15:0] ins, input logic [15:0] din,
                         output logic [15:0] f, output logic c, output logic v,
                         output logic le);
        logic [15:0] a, b;
        int ua, ub, sa, sb, s;
        a = mr[ins[5:3]]; b = mr[ins[2:0]];
        ua = int'(a); ub = int'(b);
        sa = int'($signed(a)); sb = int'($signed(b));
        f = 16'h0; c = 1'b0; v = 1'b0; le = 1'b1;
        case (ins[15:9])
            7'b0000000: f = a;
            7'b0000001: begin
                s = ua + 1; f = s[15:0]; c = (s > 65535);
                s = sa + 1; v = (s > 32767);
            end
            7'b0000010: begin
                s = ua + ub; f = s[15:0]; c = (s > 65535);
                s = sa + sb; v = (s > 32767) || (s < -32768);
            end
            7'b0000101: begin
                s = ua - ub; f = s[15:0]; c = (ua >= ub);
                s = sa - sb; v = (s > 32767) || (s < -32768);
            end
            7'b0001000: f = a & b;
            7'b0001001: f = a | b;
            7'b0001010: f = a ^ b;
            7'b0001011: f = ~a;
            7'b0001101: f = b / 2;
            7'b0001110: f = 16'(ub * 2);
            7'b0010000: f = din;
            default: le = 1'b0;
        endcase
    endtask

    task automatic step(logic [15:0] ins, logic [15:0] din, string req);
        logic [15:0] f; logic c, v, le;
        @(negedge clk);
        instr = ins; data_in = din;
        #1;
        model(ins, din, f, c, v, le);
        chk(a_bus, mr[ins[5:3]], "R1", "a_bus");
        chk({15'h0, load_en}, {15'h0, le}, req, "load_en");
        if (le) chk(wb_bus, f, req, "wb_bus");
        @(posedge clk);
        if (le) begin
            mr[ins[8:6]] = f;
            mc = c; mv = v; mn = f[15]; mz = (f == 16'h0);
        end
        #1;
        chk({12'h0, flag_c, flag_n, flag_z, flag_v}, {12'h0, mc, mn, mz, mv}, req, "flags C,N,Z,V");
    endtask

    task automatic peek_all(string req);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            instr = mk(7'b1111111, 0, i, 0);
            #1;
            chk(a_bus, mr[i], req, $sformatf("reg %0d", i));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        instr = 16'hFE00;
        @(posedge clk);
        for (int i = 0; i < 8; i++) mr[i] = 16'h0;
        {mc, mn, mz, mv} = 4'b0;
        #1;
        chk({12'h0, flag_c, flag_n, flag_z, flag_v}, 16'h0, "R2", "flags after reset");
        peek_all("R2");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(5.0 * 200000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        do_reset();
        // R8 load distinct values through the data bus
        step(mk(7'b0010000, 0, 0, 0), 16'h0000, "R8");
        step(mk(7'b0010000, 1, 0, 0), 16'h8001, "R8");
        step(mk(7'b0010000, 2, 0, 0), 16'h0003, "R8");
        step(mk(7'b0010000, 3, 0, 0), 16'h0010, "R8");
        step(mk(7'b0010000, 4, 0, 0), 16'h7FFF, "R8");
        step(mk(7'b0010000, 5, 0, 0), 16'hFFFF, "R8");
        step(mk(7'b0010000, 6, 0, 0), 16'hA5A5, "R8");
        step(mk(7'b0010000, 7, 0, 0), 16'h8000, "R8");
        peek_all("R8");
        // R9 zero flag on a zero load
        step(mk(7'b0010000, 0, 0, 0), 16'h0000, "R9");
        // R4 subtract example: R1 = R3 - R2
        step(16'b0000101_001_011_010, 16'h0, "R4");
        step(mk(7'b0000101, 0, 2, 2), 16'h0, "R4");      // equal: zero, carry 1
        step(mk(7'b0000101, 0, 2, 3), 16'h0, "R4");      // borrow
        step(mk(7'b0000101, 0, 7, 2), 16'h0, "R5");      // 8000-3 overflow
        // R3 move, add, increment
        step(mk(7'b0000000, 0, 6, 0), 16'h0, "R3");
        step(mk(7'b0000010, 0, 2, 3), 16'h0, "R3");
        step(mk(7'b0000010, 0, 5, 2), 16'h0, "R3");      // carry only
        step(mk(7'b0000010, 0, 4, 4), 16'h0, "R5");      // overflow only
        step(mk(7'b0000001, 0, 4, 0), 16'h0, "R5");      // 7FFF+1
        step(mk(7'b0000001, 0, 5, 0), 16'h0, "R3");      // FFFF+1 zero carry
        // R11 read of the destination returns old value; write lands next cycle
        step(mk(7'b0000001, 2, 2, 0), 16'h0, "R11");
        step(mk(7'b0000000, 0, 2, 0), 16'h0, "R11");
        // R10 unsupported opcode after a carry-setting add
        step(mk(7'b0000010, 0, 5, 5), 16'h0, "R3");
        step(mk(7'b1111111, 3, 6, 6), 16'h1234, "R10");
        step(mk(7'b0000011, 5, 6, 6), 16'h1234, "R10");
        step(mk(7'b0010001, 6, 6, 6), 16'h1234, "R10");
        peek_all("R10");
        // R6 logic
        step(mk(7'b0001000, 0, 6, 5), 16'h0, "R6");
        step(mk(7'b0001001, 0, 6, 1), 16'h0, "R6");
        step(mk(7'b0001010, 0, 6, 5), 16'h0, "R6");
        step(mk(7'b0001011, 0, 6, 0), 16'h0, "R6");
        // R7 shifts
        step(mk(7'b0001101, 0, 0, 6), 16'h0, "R7");
        step(mk(7'b0001110, 0, 0, 6), 16'h0, "R7");
        step(mk(7'b0001110, 0, 0, 7), 16'h0, "R7");      // 8000<<1 = 0
        step(mk(7'b0001101, 0, 0, 1), 16'h0, "R7");
        // R2 mid-run reset
        do_reset();
        // mixed pseudo-random run
        lfsr = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            logic [6:0] op;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (lfsr[3:0] % 12)
                0: op = 7'b0000000; 1: op = 7'b0000001; 2: op = 7'b0000010;
                3: op = 7'b0000101; 4: op = 7'b0001000; 5: op = 7'b0001001;
                6: op = 7'b0001010; 7: op = 7'b0001011; 8: op = 7'b0001101;
                9: op = 7'b0001110; 10: op = 7'b0010000; default: op = 7'b0111111;
            endcase
            step({op, lfsr[12:4]}, {lfsr[7:0], lfsr[15:8]} ^ 16'(k), "R9");
        end
        peek_all("R11");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule